// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block turns one core request into the strobe pattern of a single external memory access. The request arrives on a valid/ready handshake. An address decoder supplies a hit flag and a window index. For every window the sequencer receives a read and a write set of timing fields. It also receives a default set that is used when no window matches.

An access has three phases. The chip select of the window goes low first and stays low for the setup clocks. The read or write strobe is then low for one clock plus the wait clocks. The hold clocks follow, with the strobe released and the chip select still low. The core is stalled until the final cycle of the access, where `req_ready` is high.

After a read, the block keeps the bus quiet for a per-window number of clocks before a different device, or any write, may use it. A window whose read setup and read hold are both zero keeps the read strobe and its chip select low across back-to-back reads. A drive bit decides whether the pins stay driven while the bus is idle.

Top module: `ebus_seq`

## Requirements
- R1: After reset, and while idle, every chip select, `rd_n` and `wr_n` are high, `req_ready` is low and `data_oe` is low.
- R2: A read to window w asserts only `cs_n[w]` (low). It has S clocks with the strobe high (S = read setup, 0..3), then 1+W clocks with `rd_n` low (W = read wait), then H clocks with the strobe high and `cs_n[w]` still low (H = read hold, 0..3).
- R3: A write uses the write setup, write wait and write hold fields in the same three-phase shape as a read, on `wr_n`. `data_oe` is high in every cycle of the write, and `rd_n` stays high.
- R4: `req_ready` is high for exactly one cycle per access: the last cycle of that access.
- R5: A wait field of 31 lasts the same as 30, so the strobe phase is 31 clocks long.
- R6: When `dec_hit` is low, no chip select is asserted. The strobe lasts 1 + default wait clocks, using `dflt_rd_wait` for reads and `dflt_wr_wait` for writes, with no setup or hold.
- R7: A read sets a turnaround value M: the window's post-read field, or `dflt_post_rd` when there was no hit. Between the last active cycle of that read and the first active cycle of the next access to a different target, or of any write, at least max(M,1) cycles pass with no chip select and no strobe. A request issued at once sees exactly max(M,1).
- R8: A read to the same target as the previous read is not delayed by the turnaround. When issued at once, it starts after a single idle cycle.
- R9: For a window with read setup and read hold both zero, a read issued right after a read to the same window keeps `rd_n` and that window's chip select low without a break. The second read's strobe is 1+W clocks long.
- R10: When the cycle after such a read brings no matching read, `rd_n` and the chip select rise in the next cycle. The turnaround of R7 counts from that cycle.
- R11: `pin_oe` is high in every cycle of an access, including the held cycle of R9. While idle it equals `dflt_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests an access; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | High in the last cycle of the access |
| dec_hit | input | 1 | Decoder matched a window |
| dec_win | input | WIN_W | Index of the matched window |
| win_rd_wait | input | NWIN*5 | Per-window read wait clocks |
| win_wr_wait | input | NWIN*5 | Per-window write wait clocks |
| win_rd_setup | input | NWIN*2 | Per-window read setup clocks |
| win_rd_hold | input | NWIN*2 | Per-window read hold clocks |
| win_wr_setup | input | NWIN*2 | Per-window write setup clocks |
| win_wr_hold | input | NWIN*2 | Per-window write hold clocks |
| win_post_rd | input | NWIN*3 | Per-window turnaround after a read |
| dflt_drive | input | 1 | Keep pins driven while idle |
| dflt_post_rd | input | 3 | Turnaround after an unmatched read |
| dflt_rd_wait | input | 5 | Read wait for unmatched accesses |
| dflt_wr_wait | input | 5 | Write wait for unmatched accesses |
| cs_n | output | NWIN | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| data_oe | output | 1 | Data bus output enable |
| pin_oe | output | 1 | External pins driven |

## Verification
The bench builds the block with its default of four windows, so every chip select line and its one-hot pattern is exercised. The full 5-bit wait width lets the bench program 31 and observe the clamp. The 3-bit post-read field gives turnaround values large enough to tell max(M,1) apart from the single idle cycle that a same-target read sees. Separate windows hold long setup and hold values, zero setup and hold, and distinct turnaround values. This lets a single run chain reads, writes, default accesses and held reads back to back.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

    localparam int WAIT_W   = 5;
    localparam int EDGE_W   = 2;
    localparam int GAP_W    = 3;
    localparam int WAIT_MAX = 30;

    typedef logic [WAIT_W-1:0] wait_t;
    typedef logic [EDGE_W-1:0] edge_t;
    typedef logic [GAP_W-1:0]  gap_t;

    typedef struct packed {
        edge_t setup;
        wait_t wait_n;
        edge_t hold;
        gap_t  gap;
    } phase_tim_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_LINGER
    } seq_state_t;

    function automatic wait_t clamp_wait(input wait_t w);
        return (w == '1) ? wait_t'(WAIT_MAX) : w;
    endfunction

endpackage

// File: rtl/ebus_tim_sel.sv
module ebus_tim_sel
    import ebus_seq_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int WIN_W = 2
) (
    input  logic                    is_write,
    input  logic                    hit,
    input  logic [WIN_W-1:0]        win,
    input  logic [NWIN*WAIT_W-1:0]  win_rd_wait,
    input  logic [NWIN*WAIT_W-1:0]  win_wr_wait,
    input  logic [NWIN*EDGE_W-1:0]  win_rd_setup,
    input  logic [NWIN*EDGE_W-1:0]  win_rd_hold,
    input  logic [NWIN*EDGE_W-1:0]  win_wr_setup,
    input  logic [NWIN*EDGE_W-1:0]  win_wr_hold,
    input  logic [NWIN*GAP_W-1:0]   win_post_rd,
    input  gap_t                    dflt_post_rd,
    input  wait_t                   dflt_rd_wait,
    input  wait_t                   dflt_wr_wait,
    output phase_tim_t              tim,
    output logic                    consec_ok
);

    wait_t rd_wait_a  [NWIN];
    wait_t wr_wait_a  [NWIN];
    edge_t rd_setup_a [NWIN];
    edge_t rd_hold_a  [NWIN];
    edge_t wr_setup_a [NWIN];
    edge_t wr_hold_a  [NWIN];
    gap_t  gap_a      [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_unpack
        assign rd_wait_a[g]  = win_rd_wait[g*WAIT_W +: WAIT_W];
        assign wr_wait_a[g]  = win_wr_wait[g*WAIT_W +: WAIT_W];
        assign rd_setup_a[g] = win_rd_setup[g*EDGE_W +: EDGE_W];
        assign rd_hold_a[g]  = win_rd_hold[g*EDGE_W +: EDGE_W];
        assign wr_setup_a[g] = win_wr_setup[g*EDGE_W +: EDGE_W];
        assign wr_hold_a[g]  = win_wr_hold[g*EDGE_W +: EDGE_W];
        assign gap_a[g]      = win_post_rd[g*GAP_W +: GAP_W];
    end

    always_comb begin
        tim.setup  = '0;
        tim.hold   = '0;
        tim.wait_n = clamp_wait(is_write ? dflt_wr_wait : dflt_rd_wait);
        tim.gap    = dflt_post_rd;
        consec_ok  = 1'b0;
        if (hit) begin
            for (int i = 0; i < NWIN; i++) begin
                if (win == WIN_W'(i)) begin
                    tim.setup  = is_write ? wr_setup_a[i] : rd_setup_a[i];
                    tim.hold   = is_write ? wr_hold_a[i]  : rd_hold_a[i];
                    tim.wait_n = clamp_wait(is_write ? wr_wait_a[i] : rd_wait_a[i]);
                    tim.gap    = gap_a[i];
                    consec_ok  = !is_write && (rd_setup_a[i] == '0) && (rd_hold_a[i] == '0);
                end
            end
        end
    end

endmodule

// File: rtl/ebus_turnaround.sv
module ebus_turnaround
    import ebus_seq_pkg::*;
#(
    parameter int WIN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  gap_t             load_val,
    input  logic             last_hit,
    input  logic [WIN_W-1:0] last_win,
    input  logic             req_write,
    input  logic             req_hit,
    input  logic [WIN_W-1:0] req_win,
    output logic             allow
);

    gap_t             gap_q;
    logic             hit_q;
    logic [WIN_W-1:0] win_q;
    logic             same_tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            hit_q <= 1'b0;
            win_q <= '0;
        end else if (load) begin
            gap_q <= load_val;
            hit_q <= last_hit;
            win_q <= last_win;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - gap_t'(1);
        end
    end

    // a read to the device that was just read needs no quiet time
    assign same_tgt = !req_write && (req_hit == hit_q) && (!req_hit || (req_win == win_q));
    assign allow    = (gap_q <= gap_t'(1)) || same_tgt;

endmodule

// File: rtl/ebus_phase_fsm.sv
module ebus_phase_fsm
    import ebus_seq_pkg::*;
#(
    parameter int WIN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_hit,
    input  logic [WIN_W-1:0] req_win,
    input  phase_tim_t       req_tim,
    input  logic             req_consec,
    input  logic             allow,
    output seq_state_t       state,
    output logic             cur_write,
    output logic             cur_hit,
    output logic [WIN_W-1:0] cur_win,
    output logic             req_ready,
    output logic             gap_load,
    output gap_t             gap_val
);

    seq_state_t       state_q, state_d;
    wait_t            cnt_q, cnt_d;
    wait_t            wait_q;
    edge_t            hold_q;
    gap_t             gap_q;
    logic             consec_q, wr_q, hit_q;
    logic [WIN_W-1:0] win_q;
    logic             take;
    logic             cnt_zero;
    logic             linger_match;

    assign cnt_zero     = (cnt_q == '0);
    assign linger_match = req_valid && !req_write && req_hit && (req_win == win_q) && req_consec;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        take      = 1'b0;
        req_ready = 1'b0;
        gap_load  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid && allow) begin
                    take = 1'b1;
                    if (req_tim.setup != '0) begin
                        state_d = ST_SETUP;
                        cnt_d   = wait_t'(req_tim.setup) - wait_t'(1);
                    end else begin
                        state_d = ST_STROBE;
                        cnt_d   = req_tim.wait_n;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d = ST_STROBE;
                    cnt_d   = wait_q;
                end else begin
                    cnt_d = cnt_q - wait_t'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    if (hold_q != '0) begin
                        state_d = ST_HOLD;
                        cnt_d   = wait_t'(hold_q) - wait_t'(1);
                    end else begin
                        req_ready = 1'b1;
                        state_d   = (!wr_q && consec_q) ? ST_LINGER : ST_IDLE;
                        gap_load  = !wr_q && !consec_q;
                    end
                end else begin
                    cnt_d = cnt_q - wait_t'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    req_ready = 1'b1;
                    state_d   = (!wr_q && consec_q) ? ST_LINGER : ST_IDLE;
                    gap_load  = !wr_q && !consec_q;
                end else begin
                    cnt_d = cnt_q - wait_t'(1);
                end
            end
            ST_LINGER: begin
                if (linger_match) begin
                    take    = 1'b1;
                    state_d = ST_STROBE;
                    cnt_d   = req_tim.wait_n;
                end else begin
                    state_d  = ST_IDLE;
                    gap_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            wait_q   <= '0;
            hold_q   <= '0;
            gap_q    <= '0;
            consec_q <= 1'b0;
            wr_q     <= 1'b0;
            hit_q    <= 1'b0;
            win_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take) begin
                wait_q   <= req_tim.wait_n;
                hold_q   <= req_tim.hold;
                gap_q    <= req_tim.gap;
                consec_q <= req_consec;
                wr_q     <= req_write;
                hit_q    <= req_hit;
                win_q    <= req_win;
            end
        end
    end

    assign state     = state_q;
    assign cur_write = wr_q;
    assign cur_hit   = hit_q;
    assign cur_win   = win_q;
    assign gap_val   = gap_q;

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_seq_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    output logic                   req_ready,
    input  logic                   dec_hit,
    input  logic [WIN_W-1:0]       dec_win,
    input  logic [NWIN*WAIT_W-1:0] win_rd_wait,
    input  logic [NWIN*WAIT_W-1:0] win_wr_wait,
    input  logic [NWIN*EDGE_W-1:0] win_rd_setup,
    input  logic [NWIN*EDGE_W-1:0] win_rd_hold,
    input  logic [NWIN*EDGE_W-1:0] win_wr_setup,
    input  logic [NWIN*EDGE_W-1:0] win_wr_hold,
    input  logic [NWIN*GAP_W-1:0]  win_post_rd,
    input  logic                   dflt_drive,
    input  logic [GAP_W-1:0]       dflt_post_rd,
    input  logic [WAIT_W-1:0]      dflt_rd_wait,
    input  logic [WAIT_W-1:0]      dflt_wr_wait,
    output logic [NWIN-1:0]        cs_n,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   data_oe,
    output logic                   pin_oe
);

    phase_tim_t       sel_tim;
    logic             sel_consec;
    logic             allow;
    seq_state_t       state;
    logic             cur_write, cur_hit;
    logic [WIN_W-1:0] cur_win;
    logic             gap_load;
    gap_t             gap_val;
    logic             active;

    ebus_tim_sel #(.NWIN(NWIN), .WIN_W(WIN_W)) u_sel (
        .is_write     (req_write),
        .hit          (dec_hit),
        .win          (dec_win),
        .win_rd_wait  (win_rd_wait),
        .win_wr_wait  (win_wr_wait),
        .win_rd_setup (win_rd_setup),
        .win_rd_hold  (win_rd_hold),
        .win_wr_setup (win_wr_setup),
        .win_wr_hold  (win_wr_hold),
        .win_post_rd  (win_post_rd),
        .dflt_post_rd (dflt_post_rd),
        .dflt_rd_wait (dflt_rd_wait),
        .dflt_wr_wait (dflt_wr_wait),
        .tim          (sel_tim),
        .consec_ok    (sel_consec)
    );

    ebus_turnaround #(.WIN_W(WIN_W)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .load      (gap_load),
        .load_val  (gap_val),
        .last_hit  (cur_hit),
        .last_win  (cur_win),
        .req_write (req_write),
        .req_hit   (dec_hit),
        .req_win   (dec_win),
        .allow     (allow)
    );

    ebus_phase_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_hit    (dec_hit),
        .req_win    (dec_win),
        .req_tim    (sel_tim),
        .req_consec (sel_consec),
        .allow      (allow),
        .state      (state),
        .cur_write  (cur_write),
        .cur_hit    (cur_hit),
        .cur_win    (cur_win),
        .req_ready  (req_ready),
        .gap_load   (gap_load),
        .gap_val    (gap_val)
    );

    assign active = (state != ST_IDLE);

    for (genvar g = 0; g < NWIN; g++) begin : g_cs
        assign cs_n[g] = !(active && cur_hit && (cur_win == WIN_W'(g)));
    end

    assign rd_n    = !(((state == ST_STROBE) && !cur_write) || (state == ST_LINGER));
    assign wr_n    = !((state == ST_STROBE) && cur_write);
    assign data_oe = active && cur_write;
    assign pin_oe  = dflt_drive || active;

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int NWIN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            req_ready,
    input logic [NWIN-1:0] cs_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            data_oe,
    input logic            pin_oe
);

    logic [5:0] wr_run;

    always_ff @(posedge clk) begin
        if (rst)       wr_run <= '0;
        else if (!wr_n) wr_run <= wr_run + 6'd1;
        else           wr_run <= '0;
    end

    a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    a_r4_ready_active: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((cs_n != '1) || !rd_n || !wr_n));

    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    a_r3_oe_on_write: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> data_oe);

    a_r3_oe_off_read: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !data_oe);

    a_r11_pins_driven: assert property (@(posedge clk) disable iff (rst)
        ((cs_n != '1) || !rd_n || !wr_n || data_oe) |-> pin_oe);

    a_r5_wr_bounded: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (wr_run < 6'd31));

endmodule

bind ebus_seq ebus_seq_chk #(.NWIN(NWIN)) u_ebus_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .data_oe   (data_oe),
    .pin_oe    (pin_oe)
);

// File: tb/ebus_seq_bench.sv
`timescale 1ns/1ps
module ebus_seq_bench;

    localparam int NW = 4;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, dec_hit = 1'b0;
    logic [WW-1:0] dec_win = '0;
    logic [NW*5-1:0] win_rd_wait = '0, win_wr_wait = '0;
    logic [NW*2-1:0] win_rd_setup = '0, win_rd_hold = '0, win_wr_setup = '0, win_wr_hold = '0;
    logic [NW*3-1:0] win_post_rd = '0;
    logic          dflt_drive = 1'b0;
    logic [2:0]    dflt_post_rd = 3'd0;
    logic [4:0]    dflt_rd_wait = 5'd27, dflt_wr_wait = 5'd15;
    logic          req_ready, rd_n, wr_n, data_oe, pin_oe;
    logic [NW-1:0] cs_n;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    ebus_seq #(.NWIN(NW)) u_ebus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .dec_hit(dec_hit), .dec_win(dec_win),
        .win_rd_wait(win_rd_wait), .win_wr_wait(win_wr_wait),
        .win_rd_setup(win_rd_setup), .win_rd_hold(win_rd_hold),
        .win_wr_setup(win_wr_setup), .win_wr_hold(win_wr_hold),
        .win_post_rd(win_post_rd), .dflt_drive(dflt_drive),
        .dflt_post_rd(dflt_post_rd), .dflt_rd_wait(dflt_rd_wait),
        .dflt_wr_wait(dflt_wr_wait), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .data_oe(data_oe), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_win(input int i, input int rsu, input int rws, input int rho,
                           input int wsu, input int wws, input int who, input int gap);
        win_rd_setup[i*2 +: 2] = 2'(rsu);
        win_rd_wait[i*5 +: 5]  = 5'(rws);
        win_rd_hold[i*2 +: 2]  = 2'(rho);
        win_wr_setup[i*2 +: 2] = 2'(wsu);
        win_wr_wait[i*5 +: 5]  = 5'(wws);
        win_wr_hold[i*2 +: 2]  = 2'(who);
        win_post_rd[i*3 +: 3]  = 3'(gap);
    endtask

    // called at a negedge; returns at the negedge of the ready cycle
    task automatic run_access(input logic wr, input logic h, input int w,
                              output int lead, output int su, output int st,
                              output int ho, output int bad);
        int   ph;
        logic any_cs, on, other, match;
        lead = 0; su = 0; st = 0; ho = 0; bad = 0; ph = 0;
        req_valid = 1'b1; req_write = wr; dec_hit = h; dec_win = WW'(w);
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            any_cs = (cs_n != '1);
            on     = wr ? !wr_n : !rd_n;
            other  = wr ? !rd_n : !wr_n;
            match  = h ? (cs_n == ~(NW'(1) << w)) : !any_cs;
            if (ph == 0 && !any_cs && !on && !req_ready) begin
                lead++;
            end else begin
                if (!match || other || (data_oe != wr) || !pin_oe) bad = 1;
                if (on) begin st++; ph = 2; end
                else if (ph < 2) begin su++; ph = 1; end
                else ho++;
            end
            if (req_ready) break;
        end
        if (!req_ready) bad = 1;
    endtask

    task automatic expect_acc(input string tag, input int el, input int es,
                              input int et, input int eh,
                              input logic wr, input logic h, input int w);
        int l, s, t, o, b;
        run_access(wr, h, w, l, s, t, o, b);
        check({tag, " idle lead"}, l, el);
        check({tag, " setup"}, s, es);
        check({tag, " strobe"}, t, et);
        check({tag, " hold"}, o, eh);
        check({tag, " pins/select"}, b, 0);
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 ready single cycle", int'(req_ready), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cs idle", int'(cs_n), (1 << NW) - 1);
        check("R1 rd idle", int'(rd_n), 1);
        check("R1 wr idle", int'(wr_n), 1);
        check("R1 ready idle", int'(req_ready), 0);
        check("R1 data_oe idle", int'(data_oe), 0);
        check("R11 pins float", int'(pin_oe), 0);
        dflt_drive = 1'b1;
        @(negedge clk);
        check("R11 pins driven", int'(pin_oe), 1);
        dflt_drive = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_read();
        set_win(1, 2, 3, 1, 0, 0, 0, 0);
        expect_acc("R2 read w1", 0, 2, 4, 1, 1'b0, 1'b1, 1);
        release_req(); idle(10);
    endtask

    task automatic t_write();
        set_win(2, 0, 0, 1, 1, 0, 2, 0);
        expect_acc("R3 write w2", 0, 1, 1, 2, 1'b1, 1'b1, 2);
        release_req(); idle(10);
    endtask

    task automatic t_clamp();
        set_win(0, 0, 31, 0, 0, 31, 0, 0);
        expect_acc("R5 read wait 31", 0, 0, 31, 0, 1'b0, 1'b1, 0);
        release_req(); idle(10);
        expect_acc("R5 write wait 31", 0, 0, 31, 0, 1'b1, 1'b1, 0);
        release_req(); idle(10);
    endtask

    task automatic t_default();
        dflt_rd_wait = 5'd4; dflt_wr_wait = 5'd2; dflt_post_rd = 3'd0;
        expect_acc("R6 default read", 0, 0, 5, 0, 1'b0, 1'b0, 0);
        release_req(); idle(10);
        expect_acc("R6 default write", 0, 0, 3, 0, 1'b1, 1'b0, 0);
        release_req(); idle(10);
    endtask

    task automatic t_gap();
        set_win(1, 1, 0, 0, 0, 0, 0, 3);
        set_win(2, 0, 0, 1, 0, 0, 0, 0);
        expect_acc("R7 first read w1", 0, 1, 1, 0, 1'b0, 1'b1, 1);
        @(negedge clk);
        expect_acc("R8 same-target read", 0, 1, 1, 0, 1'b0, 1'b1, 1);
        @(negedge clk);
        // max(3,1)=3 idle cycles, one of them before the first sample
        expect_acc("R7 other window read", 2, 0, 1, 1, 1'b0, 1'b1, 2);
        release_req(); idle(10);
        expect_acc("R7 read before write", 0, 1, 1, 0, 1'b0, 1'b1, 1);
        @(negedge clk);
        expect_acc("R7 write same window", 2, 0, 1, 0, 1'b1, 1'b1, 1);
        release_req(); idle(10);
        dflt_post_rd = 3'd5; dflt_rd_wait = 5'd0;
        expect_acc("R7 default read", 0, 0, 1, 0, 1'b0, 1'b0, 0);
        @(negedge clk);
        expect_acc("R7 after default gap", 4, 0, 1, 1, 1'b0, 1'b1, 2);
        release_req(); idle(10);
    endtask

    task automatic t_consec();
        set_win(3, 0, 1, 0, 0, 0, 0, 2);
        set_win(1, 1, 0, 0, 0, 0, 0, 0);
        expect_acc("R9 first held read", 0, 0, 2, 0, 1'b0, 1'b1, 3);
        @(negedge clk);
        check("R9 rd held low", int'(rd_n), 0);
        check("R9 cs held low", int'(cs_n[3]), 0);
        check("R11 pins during hold", int'(pin_oe), 1);
        expect_acc("R9 second held read", 0, 0, 2, 0, 1'b0, 1'b1, 3);
        @(negedge clk);
        check("R10 rd still held", int'(rd_n), 0);
        expect_acc("R10 gap after hold", 2, 1, 1, 0, 1'b0, 1'b1, 1);
        release_req();
        check("R10 rd released", int'(rd_n), 1);
        idle(10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_clamp();
        t_default();
        t_gap();
        t_consec();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule